// File: doc/BRIEF.md
# Power-On Reset Configuration Sequencer

This block brings a programmable device from raw power to the point where user logic may run. Once power is good it waits out a power-on delay, whose length is picked by a strap pin, and for that whole time it pulls a shared open-drain status line low and holds every user I/O in high impedance. When the delay expires it lets go of the status line, which an external resistor then pulls up. Any other agent on the board may keep that line low to stretch the reset.

After power-on the sequencer passes through three further stages, always in the same order: reset, configuration and initialization. It stays in reset while the active-low configuration request or the sensed status line is low. Once both read high (the request's low-to-high edge is what starts the cycle), it enters configuration. It moves to initialization when the separate bitstream loader reports completion, and releases user I/O a fixed number of cycles later. Pulling the request low in configuration or initialization sends it back to reset, and the status line is driven low again. A pull-up control pin chooses whether weak pull-ups are enabled on user I/O while the pins are in high impedance after power-on.

Top module: `por_cfg_seq`

## Requirements
- R1: The power-on stage (stage code 00) lasts exactly POR_SHORT_CYC clock cycles after power-good rises when the captured delay select is high, and POR_LONG_CYC cycles when it is low; the stage code then becomes 01 (reset).
- R2: Throughout the power-on stage, stat_pull_low and io_hiz are 1 and weak_pu_en is 0.
- R3: dly_short is sampled only while pwr_ok is low; changes to it after power-good rises do not alter the power-on length.
- R4: In the reset stage stat_pull_low is 0 whenever the synchronized request is high, so the status line is left to the external pull-up.
- R5: The block stays in the reset stage (01) while the synchronized request or the synchronized status line is low, and drives stat_pull_low while the request is low; it enters configuration (10) on the third clock edge after the last of the two inputs goes high.
- R6: In configuration, load_done high at a clock edge moves the stage to initialization (11) at that edge; load_done has no effect in any other stage.
- R7: io_hiz stays 1 until the initialization stage has been shown for INIT_CYC cycles, and is 0 from the next cycle while the stage remains 11.
- R8: A low cfg_req_n in configuration or initialization returns the stage to reset (01) on the third clock edge, with stat_pull_low and io_hiz back at 1.
- R9: weak_pu_en is 1 exactly when pu_dis is low, the stage is not power-on, and io_hiz is 1.
- R10: pwr_ok low at a clock edge returns the stage to power-on (00) at that edge and restarts the delay count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| pwr_ok | input | 1 | Raw power-good, synchronous active-low reset of the block |
| dly_short | input | 1 | Delay strap: 1 selects the short power-on delay, 0 the long one |
| cfg_req_n | input | 1 | Configuration request, active low; its rising edge starts configuration |
| stat_in | input | 1 | Sensed level of the shared open-drain status line |
| pu_dis | input | 1 | Weak pull-up control: 0 enables pull-ups while I/O is in high impedance |
| load_done | input | 1 | Bitstream loader reports the end of configuration |
| stat_pull_low | output | 1 | 1 drives the open-drain status line low |
| io_hiz | output | 1 | 1 places all user I/O in high impedance |
| weak_pu_en | output | 1 | 1 turns on the weak pull-ups of user I/O |
| stage | output | 2 | 00 power-on, 01 reset, 10 configuration, 11 initialization |

## Verification
The assertions assume that cfg_req_n and stat_in may change at any time but are only trusted after the two-flop synchronizer, that dly_short and pu_dis are board straps held steady while power is good, and that load_done is a single-cycle pulse from the loader. The bench keeps within this by modelling the status line as a wired-AND of the block's own drive and an external hold, changing every input away from the clock edge, and toggling dly_short only during power-on to show that the captured value rules. Random seeds pick the strap values, the order and length of the request and status holds, the time spent in configuration and the stage in which the request is withdrawn.

// File: rtl/por_cfg_pkg.sv
// Shared types of the power-on configuration sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package por_cfg_pkg;

    // Stage code seen on the stage output; values are part of the interface.
    typedef enum logic [1:0] {
        ST_POR  = 2'b00,
        ST_RST  = 2'b01,
        ST_CFG  = 2'b10,
        ST_INIT = 2'b11
    } stage_t;

endpackage

// File: rtl/por_sync.sv
// Two-flop synchronizer bank for asynchronous board-level inputs.
// Assumes: each bit is independent; no bus coherency is needed.
// Reset value of every stage is 0 so nothing looks released before it is.
module por_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] sh;

        // Shift the raw bit through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= 2'b00;
            else        sh <= {sh[0], d[i]};
        end

        assign q[i] = sh[1];
    end

endmodule

// File: rtl/por_timer.sv
// Shared cycle counter for the power-on delay and the initialization wait.
// Assumes: all cycle counts are at least 2 and fit in CW bits; clr pulses
// on every stage change so the count always starts from zero.
// done is high in the last cycle of the window; expired follows one cycle
// later and stays high until the next clear.
module por_timer
    import por_cfg_pkg::*;
#(
    parameter int POR_LONG_CYC  = 20_000_000,
    parameter int POR_SHORT_CYC = 2_400_000,
    parameter int INIT_CYC      = 64,
    parameter int CW            = 25
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   sel_short,
    input  stage_t stage,
    output logic   done,
    output logic   expired
);

    localparam logic [CW-1:0] LONG_M1  = CW'(POR_LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_M1 = CW'(POR_SHORT_CYC - 1);
    localparam logic [CW-1:0] INIT_M1  = CW'(INIT_CYC - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_m1;

    // Pick the terminal count for the current stage.
    always_comb begin
        if (stage == ST_POR) lim_m1 = sel_short ? SHORT_M1 : LONG_M1;
        else                 lim_m1 = INIT_M1;
    end

    assign done = (cnt == lim_m1);

    // Count up to the terminal value and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (!done)    cnt <= cnt + CW'(1);
    end

    // Remember that the window has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) expired <= 1'b0;
        else if (done)     expired <= 1'b1;
    end

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim_m1);

    assert_expired_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(done));

endmodule

// File: rtl/por_stage_fsm.sv
// Stage sequencer: power-on, reset, configuration, initialization.
// Assumes: req_ok and stat_ok are already synchronized; load_done comes
// from the bitstream loader in this clock domain.
module por_stage_fsm
    import por_cfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_ok,
    input  logic   stat_ok,
    input  logic   load_done,
    input  logic   tmr_done,
    output stage_t stage,
    output logic   stage_chg
);

    stage_t nxt;

    // Next-stage decision.
    always_comb begin
        nxt = stage;
        unique case (stage)
            ST_POR:  if (tmr_done) nxt = ST_RST;
            ST_RST:  if (req_ok && stat_ok) nxt = ST_CFG;
            ST_CFG: begin
                if (!req_ok)        nxt = ST_RST;
                else if (load_done) nxt = ST_INIT;
            end
            ST_INIT: if (!req_ok) nxt = ST_RST;
            default: nxt = ST_POR;
        endcase
    end

    assign stage_chg = (nxt != stage);

    // Stage register with synchronous reset to power-on.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= ST_POR;
        else        stage <= nxt;
    end

    assert_por_exits_to_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_POR) |=> (stage == ST_POR || stage == ST_RST));

    assert_reset_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_RST && !(req_ok && stat_ok)) |=> (stage == ST_RST));

    assert_load_starts_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_CFG && req_ok && load_done) |=> (stage == ST_INIT));

    assert_withdraw_returns_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage == ST_CFG || stage == ST_INIT) && !req_ok) |=> (stage == ST_RST));

endmodule

// File: rtl/por_cfg_seq.sv
// Power-on reset and configuration-start sequencer (top).
// Assumes: pwr_ok is already clean in this clock domain and acts as the
// synchronous active-low reset; dly_short and pu_dis are static straps;
// cfg_req_n and stat_in are asynchronous and are synchronized here.
// Outputs are decoded from registered state and synchronized inputs.
module por_cfg_seq
    import por_cfg_pkg::*;
#(
    parameter int POR_LONG_CYC  = 20_000_000,
    parameter int POR_SHORT_CYC = 2_400_000,
    parameter int INIT_CYC      = 64
) (
    input  logic       clk,
    input  logic       pwr_ok,
    input  logic       dly_short,
    input  logic       cfg_req_n,
    input  logic       stat_in,
    input  logic       pu_dis,
    input  logic       load_done,
    output logic       stat_pull_low,
    output logic       io_hiz,
    output logic       weak_pu_en,
    output logic [1:0] stage
);

    localparam int MAX_A = (POR_LONG_CYC > POR_SHORT_CYC) ? POR_LONG_CYC : POR_SHORT_CYC;
    localparam int MAX_C = (MAX_A > INIT_CYC) ? MAX_A : INIT_CYC;
    localparam int CW    = $clog2(MAX_C + 1);

    logic [1:0] raw_in;
    logic [1:0] syn_in;
    logic       req_ok;
    logic       stat_ok;
    logic       sel_q;
    logic       tmr_done;
    logic       tmr_exp;
    logic       stage_chg;
    stage_t     st;

    assign raw_in  = {stat_in, cfg_req_n};
    assign req_ok  = syn_in[0];
    assign stat_ok = syn_in[1];

    // Capture the delay strap while power is not yet good.
    always_ff @(posedge clk) begin
        if (!pwr_ok) sel_q <= dly_short;
    end

    por_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (pwr_ok),
        .d     (raw_in),
        .q     (syn_in)
    );

    por_timer #(
        .POR_LONG_CYC  (POR_LONG_CYC),
        .POR_SHORT_CYC (POR_SHORT_CYC),
        .INIT_CYC      (INIT_CYC),
        .CW            (CW)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (pwr_ok),
        .clr       (stage_chg),
        .sel_short (sel_q),
        .stage     (st),
        .done      (tmr_done),
        .expired   (tmr_exp)
    );

    por_stage_fsm u_fsm (
        .clk       (clk),
        .rst_n     (pwr_ok),
        .req_ok    (req_ok),
        .stat_ok   (stat_ok),
        .load_done (load_done),
        .tmr_done  (tmr_done),
        .stage     (st),
        .stage_chg (stage_chg)
    );

    // Decode pin controls from the stage and the synchronized request.
    always_comb begin
        stat_pull_low = (st == ST_POR) || (st == ST_RST && !req_ok);
        io_hiz        = !(st == ST_INIT && tmr_exp);
        weak_pu_en    = !pu_dis && (st != ST_POR) && io_hiz;
    end

    assign stage = st;

    assert_por_pins_R2: assert property (@(posedge clk) disable iff (!pwr_ok)
        (st == ST_POR) |-> (stat_pull_low && io_hiz && !weak_pu_en));

    assert_pullup_gate_R9: assert property (@(posedge clk) disable iff (!pwr_ok)
        weak_pu_en |-> (io_hiz && !pu_dis && st != ST_POR));

    assert_release_after_por_R4: assert property (@(posedge clk) disable iff (!pwr_ok)
        (st == ST_RST && req_ok) |-> !stat_pull_low);

endmodule

// File: tb/sim_por_cfg_seq.sv
module sim_por_cfg_seq;

    localparam int LONG  = 40;
    localparam int SHORT = 12;
    localparam int INITC = 6;

    logic       clk = 1'b0;
    logic       pwr_ok, dly_short, cfg_req_n, pu_dis, load_done, ext_hold;
    logic       stat_in, stat_pull_low, io_hiz, weak_pu_en;
    logic [1:0] stage;
    int         checks = 0;
    int         fails  = 0;
    int         cyc    = 0;

    always #2.5 clk = ~clk;

    // Wired-AND model of the shared open-drain status line.
    assign stat_in = ~stat_pull_low & ~ext_hold;

    por_cfg_seq #(
        .POR_LONG_CYC  (LONG),
        .POR_SHORT_CYC (SHORT),
        .INIT_CYC      (INITC)
    ) u0 (
        .clk           (clk),
        .pwr_ok        (pwr_ok),
        .dly_short     (dly_short),
        .cfg_req_n     (cfg_req_n),
        .stat_in       (stat_in),
        .pu_dis        (pu_dis),
        .load_done     (load_done),
        .stat_pull_low (stat_pull_low),
        .io_hiz        (io_hiz),
        .weak_pu_en    (weak_pu_en),
        .stage         (stage)
    );

    function automatic int por_len(input logic sel);
        return sel ? SHORT : LONG;
    endfunction

    function automatic int exp_pu(input logic dis, input int stg, input logic hiz);
        return (!dis && stg != 0 && hiz) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run_iter(input logic sel, input logic holds, input logic order,
                            input int hold_len, input logic pu, input logic drop_cfg,
                            input int cfg_wait);
        int len;
        len = por_len(sel);
        @(negedge clk);
        pwr_ok = 1'b0; dly_short = sel; cfg_req_n = !holds; ext_hold = holds;
        pu_dis = pu; load_done = 1'b0;
        step(2);
        chk("R10 stage on power loss", stage, 0);
        chk("R10 status drive on power loss", stat_pull_low, 1);
        pwr_ok = 1'b1;
        step(3);
        dly_short = !sel;                              // R3: ignored now
        step(len - 4);
        chk("R1 still power-on", stage, 0);
        chk("R2 status driven", stat_pull_low, 1);
        chk("R2 io hiz", io_hiz, 1);
        chk("R2 no pull-up", weak_pu_en, 0);
        step(1);
        chk("R1 R3 power-on length", stage, 1);
        chk("R9 pull-up in reset", weak_pu_en, exp_pu(pu, 1, 1'b1));
        if (!holds) begin
            chk("R4 status released", stat_pull_low, 0);
            step(2);
            chk("R5 waiting for status sync", stage, 1);
            step(1);
            chk("R5 enter configuration", stage, 2);
        end else begin
            chk("R5 request low drives status", stat_pull_low, 1);
            step(hold_len);
            chk("R5 held in reset", stage, 1);
            if (!order) begin
                cfg_req_n = 1'b1;
                step(2);
                chk("R4 status released", stat_pull_low, 0);
                step(4);
                chk("R5 external hold keeps reset", stage, 1);
                ext_hold = 1'b0;
                step(2);
                chk("R5 waiting for status sync", stage, 1);
                step(1);
                chk("R5 enter configuration", stage, 2);
            end else begin
                ext_hold = 1'b0;
                step(6);
                chk("R5 request low keeps reset", stage, 1);
                cfg_req_n = 1'b1;
                step(4);
                chk("R5 waiting for loop", stage, 1);
                step(1);
                chk("R5 enter configuration", stage, 2);
            end
        end
        step(cfg_wait);
        chk("R6 configuration waits for loader", stage, 2);
        if (drop_cfg) begin
            cfg_req_n = 1'b0;
            step(2);
            chk("R8 not yet back", stage, 2);
            step(1);
            chk("R8 back to reset", stage, 1);
            chk("R8 status driven", stat_pull_low, 1);
            chk("R8 io hiz", io_hiz, 1);
            load_done = 1'b1;
            step(1);
            chk("R6 load ignored in reset", stage, 1);
            load_done = 1'b0;
            return;
        end
        load_done = 1'b1;
        step(1);
        load_done = 1'b0;
        chk("R6 enter initialization", stage, 3);
        chk("R7 io hiz at start", io_hiz, 1);
        step(INITC - 1);
        chk("R7 io hiz at last wait cycle", io_hiz, 1);
        chk("R9 pull-up while hiz", weak_pu_en, exp_pu(pu, 3, 1'b1));
        step(1);
        chk("R7 io released", io_hiz, 0);
        chk("R9 pull-up off after release", weak_pu_en, 0);
        cfg_req_n = 1'b0;
        step(2);
        chk("R8 still initialization", stage, 3);
        step(1);
        chk("R8 back to reset", stage, 1);
        chk("R8 io hiz again", io_hiz, 1);
        chk("R8 status driven", stat_pull_low, 1);
        chk("R9 pull-up after return", weak_pu_en, exp_pu(pu, 1, 1'b1));
    endtask

    initial begin
        pwr_ok = 1'b0; dly_short = 1'b1; cfg_req_n = 1'b1; pu_dis = 1'b0;
        load_done = 1'b0; ext_hold = 1'b0;
        void'($urandom(32'd4242));
        step(2);
        chk("R10 reset stage", stage, 0);
        chk("R2 reset io hiz", io_hiz, 1);
        // Directed corners: both delay lengths, no holds, both pull-up settings.
        run_iter(1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b0, 0);
        run_iter(1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b0, 3);
        run_iter(1'b1, 1'b1, 1'b0, 1, 1'b0, 1'b1, 0);
        for (int it = 0; it < 12; it++) begin
            run_iter(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), $urandom_range(1, 20),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     $urandom_range(0, 10));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule